// File: doc/BRIEF.md
# Serial Operand-Encoding Byte Decoder

This block takes a variable-length instruction stream one byte per cycle and produces one decoded operand record for each instruction. A byte is accepted when `in_valid` and `in_ready` are both high. `long_mode` selects how the 0x40–0x4F byte range is read. In long mode those bytes are a register-extension prefix. In legacy mode they are one-byte increment and decrement opcodes.

After the opcode, the block reads the bytes that follow it in order: the operand-form byte, an optional scaled-index byte, the displacement and the immediate. Each step decides how many of the remaining bytes belong to the instruction. This includes the escape encodings that bring in a scaled-index byte, remove the base register, or force a 32-bit displacement.

It supports a small opcode subset: 0x01, 0x03, 0x89, 0x8B, 0x8D, 0x81, 0x83, 0x69, 0x90, 0x99, 0x50–0x57 and 0x40–0x4F. Any other opcode produces an error record. Decoding then starts again on the next byte.

Top module: `opdec_serial`

## Requirements
- R1: The operand-form byte carries mode in bits 7:6, reg in bits 5:3 and r/m in bits 2:0.
  - Mode 11 is register direct: `out_mem`=0 and `out_rm`={prefix bit0, r/m}.
  - Mode 00 is a memory form with no displacement, unless r/m=101 (see R3).
  - Mode 01 adds one displacement byte, sign-extended to 32 bits.
  - Mode 10 adds four displacement bytes, least significant first.
  - In memory forms without a scaled-index byte, the base is {prefix bit0, r/m} and `out_base_vld`=1.
  - This form byte is used by opcodes 0x01, 0x03, 0x89 and 0x8B.
- R2: In a memory form, r/m=100 means a scaled-index byte follows. Its fields map to the outputs as follows.
  - Bits 7:6 go to `out_scale`, where the factor is 1<<scale.
  - Bits 5:3, extended by prefix bit1, give `out_index`. An index of 0100 means no index (`out_index_vld`=0).
  - Bits 2:0, extended by prefix bit0, give `out_rm`.
  - A base field of 101 with mode 00 means no base (`out_base_vld`=0) and a 4-byte displacement.
- R3: Mode 00 with r/m=101 (no scaled-index byte) means a 4-byte displacement only, with `out_base_vld`=0 and `out_rm`={prefix bit0,101}. In long mode `out_ip_rel` is 1; in legacy mode it is 0.
- R4: In long mode, a byte 0x40–0x4F is a prefix that counts toward `out_len`.
  - Bit2 extends reg, bit1 extends the index, and bit0 extends r/m, base or the opcode register. Bit3 is ignored.
  - A second prefix is an error whose `out_opcode` is that second prefix.
- R5: In legacy mode, 0x40–0x4F is a complete one-byte instruction with `out_len`=1 and `out_reg`={0, byte bits 2:0}.
- R6: Opcodes 0x90 and 0x99 complete after the opcode byte, with no operand-form byte.
- R7: Opcodes 0x50–0x57 complete after the opcode, with `out_reg`={prefix bit0, opcode bits 2:0}.
- R8: Immediates follow the displacement, least significant byte first.
  - 0x81 and 0x69 carry 4 immediate bytes. 0x83 carries 1 byte, sign-extended.
  - For 0x81 and 0x83, `out_reg` is the raw 3-bit operation selector with bit3 forced to 0, whatever prefix bit2 says.
- R9: Opcode 0x8D with a register-direct form byte is an error of length 2 when it has no prefix.
- R10: Errors behave as follows.
  - An unsupported opcode gives `out_error`=1, `out_len` equal to the bytes consumed including the offending one, and all other fields zero except `out_opcode`.
  - The next byte is decoded as the start of a new instruction.
- R11: The record appears with `out_valid`=1 in the cycle after the final byte is accepted, for exactly one cycle, with `in_ready`=0 during that cycle. Cycles with `in_valid`=0 change nothing.
- R12: Synchronous active-high `rst` discards any partial instruction and leaves `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode | input | 1 | 1 = 64-bit decoding, 0 = legacy 32-bit decoding |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Decoded record present (one cycle) |
| out_error | output | 1 | Record is an error record |
| out_len | output | 4 | Instruction length in bytes |
| out_opcode | output | 8 | Opcode byte |
| out_reg | output | 4 | Reg-field register, opcode register or selector |
| out_rm | output | 4 | Direct register or base register number |
| out_mem | output | 1 | Operand is a memory reference |
| out_base_vld | output | 1 | Base register present |
| out_index | output | 4 | Index register number |
| out_index_vld | output | 1 | Index register present |
| out_scale | output | 2 | Index scale as log2 factor |
| out_ip_rel | output | 1 | Displacement is instruction-pointer relative |
| out_disp | output | 32 | Sign-extended displacement |
| out_imm | output | 32 | Sign-extended immediate |

## Verification
The table walks every form-byte mode, with and without prefix extension bits.

- Scaled-index bytes are tried with a normal index, the no-index code, the no-base code, and the no-index code turned into register 12 by prefix bit1. These cases separate a decoder that consumes the right number of bytes from one that only splits fields.
- Mode 00 with r/m=101 is sent in both modes to tell the pointer-relative flag apart.
- 0x41 is sent as a prefix in long mode and as a complete instruction in legacy mode.
- Back-to-back error records, followed by a good instruction, show the resynchronisation.
- Directed runs insert idle gaps between bytes and assert reset mid-instruction.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_W  = 4;
    localparam int LEN_W  = 4;
    localparam int VAL_W  = 32;
    localparam int CNT_W  = 2;
    localparam int NB_W   = 3;

    typedef enum logic [2:0] {
        ST_OP, ST_FORM, ST_SIDX, ST_DISP, ST_IMM, ST_EMIT
    } dec_state_e;

    typedef enum logic [2:0] {
        OK_BAD, OK_PREFIX, OK_BARE, OK_INCDEC, OK_PUSH, OK_FORM
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic [NB_W-1:0]    imm_bytes;
        logic               mem_only;
        logic               reg_is_sel;
    } op_info_t;

    typedef struct packed {
        logic               mem;
        logic               need_sidx;
        logic [NB_W-1:0]    disp_bytes;
        logic               ip_rel;
        logic               base_vld;
        logic [REG_W-1:0]   rm;
        logic [REG_W-1:0]   reg_n;
    } form_info_t;

    typedef struct packed {
        logic [1:0]         scale;
        logic [REG_W-1:0]   index;
        logic               index_vld;
        logic [REG_W-1:0]   base;
        logic               base_vld;
        logic               force_d32;
    } sidx_info_t;

    typedef struct packed {
        logic               err;
        logic [LEN_W-1:0]   len;
        logic [BYTE_W-1:0]  opcode;
        logic [REG_W-1:0]   reg_n;
        logic [REG_W-1:0]   rm;
        logic               mem;
        logic               base_vld;
        logic [REG_W-1:0]   index;
        logic               index_vld;
        logic [1:0]         scale;
        logic               ip_rel;
        logic [VAL_W-1:0]   disp;
        logic [VAL_W-1:0]   imm;
    } dec_rec_t;

    function automatic logic [VAL_W-1:0] sext8(input logic [BYTE_W-1:0] b);
        return {{(VAL_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

    function automatic dec_state_e after_disp(input logic [NB_W-1:0] imm_bytes);
        return (imm_bytes != '0) ? ST_IMM : ST_EMIT;
    endfunction

endpackage

// File: rtl/opdec_opclass.sv
module opdec_opclass
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    input  logic              long_mode,
    output op_info_t          info
);
    always_comb begin
        info = '0;
        info.kind = OK_BAD;
        if (op[7:4] == 4'h4) begin
            info.kind = long_mode ? OK_PREFIX : OK_INCDEC;
        end else if (op[7:3] == 5'b01010) begin
            info.kind = OK_PUSH;
        end else begin
            case (op)
                8'h90, 8'h99: info.kind = OK_BARE;
                8'h01, 8'h03, 8'h89, 8'h8B: info.kind = OK_FORM;
                8'h8D: begin
                    info.kind     = OK_FORM;
                    info.mem_only = 1'b1;
                end
                8'h81: begin
                    info.kind       = OK_FORM;
                    info.imm_bytes  = 3'd4;
                    info.reg_is_sel = 1'b1;
                end
                8'h83: begin
                    info.kind       = OK_FORM;
                    info.imm_bytes  = 3'd1;
                    info.reg_is_sel = 1'b1;
                end
                8'h69: begin
                    info.kind      = OK_FORM;
                    info.imm_bytes = 3'd4;
                end
                default: info.kind = OK_BAD;
            endcase
        end
    end
endmodule

// File: rtl/opdec_form.sv
module opdec_form
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] fb,
    input  logic              long_mode,
    input  logic              ext_r,
    input  logic              ext_b,
    input  logic              reg_is_sel,
    output form_info_t        info
);
    logic [1:0] mode_f;
    logic [2:0] reg_f;
    logic [2:0] rm_f;
    logic       abs_d32;

    assign mode_f  = fb[7:6];
    assign reg_f   = fb[5:3];
    assign rm_f    = fb[2:0];
    assign abs_d32 = (mode_f == 2'b00) && (rm_f == 3'b101);

    always_comb begin
        info.mem       = (mode_f != 2'b11);
        info.need_sidx = info.mem && (rm_f == 3'b100);
        case (mode_f)
            2'b01:   info.disp_bytes = 3'd1;
            2'b10:   info.disp_bytes = 3'd4;
            2'b00:   info.disp_bytes = abs_d32 ? 3'd4 : 3'd0;
            default: info.disp_bytes = 3'd0;
        endcase
        info.ip_rel   = abs_d32 && long_mode;
        info.base_vld = info.mem && !info.need_sidx && !abs_d32;
        info.rm       = {ext_b, rm_f};
        info.reg_n    = reg_is_sel ? {1'b0, reg_f} : {ext_r, reg_f};
        // R1
        disp_needs_mem_chk: assert (info.mem || info.disp_bytes == 3'd0);
        // R2
        sidx_needs_mem_chk: assert (!info.need_sidx || info.mem);
    end
endmodule

// File: rtl/opdec_sidx.sv
module opdec_sidx
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] sb,
    input  logic [1:0]        mode_f,
    input  logic              ext_x,
    input  logic              ext_b,
    output sidx_info_t        info
);
    logic no_base;

    assign no_base = (sb[2:0] == 3'b101) && (mode_f == 2'b00);

    always_comb begin
        info.scale     = sb[7:6];
        info.index     = {ext_x, sb[5:3]};
        info.index_vld = (info.index != 4'b0100);
        info.base      = {ext_b, sb[2:0]};
        info.base_vld  = !no_base;
        info.force_d32 = no_base;
    end
endmodule

// File: rtl/opdec_serial.sv
module opdec_serial
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              long_mode,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_error,
    output logic [3:0]        out_len,
    output logic [7:0]        out_opcode,
    output logic [3:0]        out_reg,
    output logic [3:0]        out_rm,
    output logic              out_mem,
    output logic              out_base_vld,
    output logic [3:0]        out_index,
    output logic              out_index_vld,
    output logic [1:0]        out_scale,
    output logic              out_ip_rel,
    output logic [31:0]       out_disp,
    output logic [31:0]       out_imm
);
    dec_state_e        state_q;
    logic              ext_seen_q;
    logic [2:0]        ext_q;
    logic [NB_W-1:0]   imm_bytes_q;
    logic              mem_only_q;
    logic              reg_is_sel_q;
    logic [1:0]        mode_q;
    logic [NB_W-1:0]   dlen_q;
    logic [CNT_W-1:0]  cnt_q;
    dec_rec_t          rec_q;

    op_info_t          op_info;
    form_info_t        form;
    sidx_info_t        sidx;
    logic              take;
    logic [NB_W-1:0]   sidx_dlen;

    opdec_opclass u_opclass (
        .op        (in_byte),
        .long_mode (long_mode),
        .info      (op_info)
    );

    opdec_form u_form (
        .fb         (in_byte),
        .long_mode  (long_mode),
        .ext_r      (ext_q[2]),
        .ext_b      (ext_q[0]),
        .reg_is_sel (reg_is_sel_q),
        .info       (form)
    );

    opdec_sidx u_sidx (
        .sb     (in_byte),
        .mode_f (mode_q),
        .ext_x  (ext_q[1]),
        .ext_b  (ext_q[0]),
        .info   (sidx)
    );

    assign in_ready  = (state_q != ST_EMIT);
    assign take      = in_valid && in_ready;
    assign sidx_dlen = sidx.force_d32 ? 3'd4 : dlen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_OP;
            ext_seen_q   <= 1'b0;
            ext_q        <= '0;
            imm_bytes_q  <= '0;
            mem_only_q   <= 1'b0;
            reg_is_sel_q <= 1'b0;
            mode_q       <= '0;
            dlen_q       <= '0;
            cnt_q        <= '0;
            rec_q        <= '0;
        end else begin
            case (state_q)
                ST_OP: if (take) begin
                    rec_q.len <= rec_q.len + 4'd1;
                    case (op_info.kind)
                        OK_PREFIX: begin
                            if (ext_seen_q) begin
                                rec_q.err    <= 1'b1;
                                rec_q.opcode <= in_byte;
                                state_q      <= ST_EMIT;
                            end else begin
                                ext_seen_q <= 1'b1;
                                ext_q      <= in_byte[2:0];
                            end
                        end
                        OK_BARE: begin
                            rec_q.opcode <= in_byte;
                            state_q      <= ST_EMIT;
                        end
                        OK_INCDEC: begin
                            rec_q.opcode <= in_byte;
                            rec_q.reg_n  <= {1'b0, in_byte[2:0]};
                            state_q      <= ST_EMIT;
                        end
                        OK_PUSH: begin
                            rec_q.opcode <= in_byte;
                            rec_q.reg_n  <= {ext_q[0], in_byte[2:0]};
                            state_q      <= ST_EMIT;
                        end
                        OK_FORM: begin
                            rec_q.opcode <= in_byte;
                            imm_bytes_q  <= op_info.imm_bytes;
                            mem_only_q   <= op_info.mem_only;
                            reg_is_sel_q <= op_info.reg_is_sel;
                            state_q      <= ST_FORM;
                        end
                        default: begin
                            rec_q.err    <= 1'b1;
                            rec_q.opcode <= in_byte;
                            state_q      <= ST_EMIT;
                        end
                    endcase
                end
                ST_FORM: if (take) begin
                    rec_q.len <= rec_q.len + 4'd1;
                    if (mem_only_q && !form.mem) begin
                        rec_q.err <= 1'b1;
                        state_q   <= ST_EMIT;
                    end else begin
                        rec_q.reg_n    <= form.reg_n;
                        rec_q.rm       <= form.rm;
                        rec_q.mem      <= form.mem;
                        rec_q.base_vld <= form.base_vld;
                        rec_q.ip_rel   <= form.ip_rel;
                        mode_q         <= in_byte[7:6];
                        dlen_q         <= form.disp_bytes;
                        cnt_q          <= '0;
                        if (form.need_sidx)
                            state_q <= ST_SIDX;
                        else if (form.disp_bytes != '0)
                            state_q <= ST_DISP;
                        else
                            state_q <= after_disp(imm_bytes_q);
                    end
                end
                ST_SIDX: if (take) begin
                    rec_q.len       <= rec_q.len + 4'd1;
                    rec_q.scale     <= sidx.scale;
                    rec_q.index     <= sidx.index;
                    rec_q.index_vld <= sidx.index_vld;
                    rec_q.rm        <= sidx.base;
                    rec_q.base_vld  <= sidx.base_vld;
                    dlen_q          <= sidx_dlen;
                    state_q         <= (sidx_dlen != '0) ? ST_DISP : after_disp(imm_bytes_q);
                end
                ST_DISP: if (take) begin
                    rec_q.len <= rec_q.len + 4'd1;
                    if (dlen_q == 3'd1)
                        rec_q.disp <= sext8(in_byte);
                    else
                        rec_q.disp[8*cnt_q +: 8] <= in_byte;
                    if ({1'b0, cnt_q} == dlen_q - 3'd1) begin
                        cnt_q   <= '0;
                        state_q <= after_disp(imm_bytes_q);
                    end else begin
                        cnt_q <= cnt_q + 2'd1;
                    end
                end
                ST_IMM: if (take) begin
                    rec_q.len <= rec_q.len + 4'd1;
                    if (imm_bytes_q == 3'd1)
                        rec_q.imm <= sext8(in_byte);
                    else
                        rec_q.imm[8*cnt_q +: 8] <= in_byte;
                    if ({1'b0, cnt_q} == imm_bytes_q - 3'd1) begin
                        cnt_q   <= '0;
                        state_q <= ST_EMIT;
                    end else begin
                        cnt_q <= cnt_q + 2'd1;
                    end
                end
                ST_EMIT: begin
                    state_q      <= ST_OP;
                    rec_q        <= '0;
                    ext_seen_q   <= 1'b0;
                    ext_q        <= '0;
                    imm_bytes_q  <= '0;
                    mem_only_q   <= 1'b0;
                    reg_is_sel_q <= 1'b0;
                    cnt_q        <= '0;
                end
                default: state_q <= ST_OP;
            endcase
        end
    end

    assign out_valid     = (state_q == ST_EMIT);
    assign out_error     = rec_q.err;
    assign out_len       = rec_q.len;
    assign out_opcode    = rec_q.opcode;
    assign out_reg       = rec_q.reg_n;
    assign out_rm        = rec_q.rm;
    assign out_mem       = rec_q.mem;
    assign out_base_vld  = rec_q.base_vld;
    assign out_index     = rec_q.index;
    assign out_index_vld = rec_q.index_vld;
    assign out_scale     = rec_q.scale;
    assign out_ip_rel    = rec_q.ip_rel;
    assign out_disp      = rec_q.disp;
    assign out_imm       = rec_q.imm;

    // R11
    emit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> !out_valid);
    // R3
    iprel_form_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ip_rel) |-> (out_mem && !out_base_vld && !out_error));
    // R9
    addr_calc_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_error && out_opcode == 8'h8D) |-> out_mem);
    // R8
    imm8_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_error && out_opcode == 8'h83) |-> (out_imm[31:8] == {24{out_imm[7]}}));
    // R2
    index_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_index_vld) |-> (out_mem && out_index != 4'd4));
    // R10
    len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len != 4'd0 && out_len <= 4'd12));
    // R12
    post_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));
endmodule

// File: tb/opdec_serial_bench.sv
`timescale 1ns/1ps
module opdec_serial_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        long_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, out_valid, out_error, out_mem, out_base_vld;
    logic        out_index_vld, out_ip_rel;
    logic [3:0]  out_len, out_reg, out_rm, out_index;
    logic [7:0]  out_opcode;
    logic [1:0]  out_scale;
    logic [31:0] out_disp, out_imm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    opdec_serial u_opdec_serial (
        .clk(clk), .rst(rst), .long_mode(long_mode), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .out_valid(out_valid),
        .out_error(out_error), .out_len(out_len), .out_opcode(out_opcode),
        .out_reg(out_reg), .out_rm(out_rm), .out_mem(out_mem),
        .out_base_vld(out_base_vld), .out_index(out_index),
        .out_index_vld(out_index_vld), .out_scale(out_scale),
        .out_ip_rel(out_ip_rel), .out_disp(out_disp), .out_imm(out_imm)
    );

    typedef struct packed {
        logic        lm;
        logic [3:0]  n;
        logic [95:0] b;
        logic        err;
        logic [3:0]  len;
        logic [7:0]  opc;
        logic [3:0]  rg;
        logic [3:0]  rm;
        logic        mem;
        logic        bv;
        logic [3:0]  idx;
        logic        iv;
        logic [1:0]  sc;
        logic        ipr;
        logic [31:0] disp;
        logic [31:0] imm;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    // fields: mode, nbytes, bytes, err, len, opcode, reg, rm, mem, base_vld, index, index_vld, scale, ip_rel, disp, imm, req
    localparam vec_t VECS [NV] = '{
        // R1 register direct
        '{1'b1, 4'd2, 96'h8BC8, 1'b0, 4'd2, 8'h8B, 4'd1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd1},
        // R4 prefix extends reg and r/m
        '{1'b1, 4'd3, 96'h4D8BC8, 1'b0, 4'd3, 8'h8B, 4'd9, 4'd8, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd4},
        // R1 indirect, no displacement
        '{1'b1, 4'd2, 96'h0307, 1'b0, 4'd2, 8'h03, 4'd0, 4'd7, 1'b1, 1'b1, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd1},
        // R1 one-byte displacement, sign-extended
        '{1'b1, 4'd3, 96'h8945F8, 1'b0, 4'd3, 8'h89, 4'd0, 4'd5, 1'b1, 1'b1, 4'd0, 1'b0, 2'd0, 1'b0, 32'hFFFFFFF8, 32'h0, 4'd1},
        // R3 long mode pointer-relative
        '{1'b1, 4'd6, 96'h8B0578563412, 1'b0, 4'd6, 8'h8B, 4'd0, 4'd5, 1'b1, 1'b0, 4'd0, 1'b0, 2'd0, 1'b1, 32'h12345678, 32'h0, 4'd3},
        // R3 legacy mode absolute
        '{1'b0, 4'd6, 96'h8B0578563412, 1'b0, 4'd6, 8'h8B, 4'd0, 4'd5, 1'b1, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h12345678, 32'h0, 4'd3},
        // R2 scaled index x4
        '{1'b1, 4'd3, 96'h8B0488, 1'b0, 4'd3, 8'h8B, 4'd0, 4'd0, 1'b1, 1'b1, 4'd1, 1'b1, 2'd2, 1'b0, 32'h0, 32'h0, 4'd2},
        // R2 scaled index with disp8 on 0x8D
        '{1'b1, 4'd4, 96'h8D447F7B, 1'b0, 4'd4, 8'h8D, 4'd0, 4'd7, 1'b1, 1'b1, 4'd7, 1'b1, 2'd1, 1'b0, 32'h7B, 32'h0, 4'd2},
        // R2 no index, no base, disp32
        '{1'b1, 4'd7, 96'h8B042544332211, 1'b0, 4'd7, 8'h8B, 4'd0, 4'd5, 1'b1, 1'b0, 4'd4, 1'b0, 2'd0, 1'b0, 32'h11223344, 32'h0, 4'd2},
        // R4 prefix bit1 turns index 100 into register 12
        '{1'b1, 4'd8, 96'h428B042544332211, 1'b0, 4'd8, 8'h8B, 4'd0, 4'd5, 1'b1, 1'b0, 4'd12, 1'b1, 2'd0, 1'b0, 32'h11223344, 32'h0, 4'd4},
        // R4 prefix bit0 extends base with mode 01
        '{1'b1, 4'd4, 96'h418B4500, 1'b0, 4'd4, 8'h8B, 4'd0, 4'd13, 1'b1, 1'b1, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd4},
        // R8 imm32 with selector
        '{1'b1, 4'd6, 96'h81C178563412, 1'b0, 4'd6, 8'h81, 4'd0, 4'd1, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h12345678, 4'd8},
        // R8 imm8 sign-extended, selector ignores prefix bit2
        '{1'b1, 4'd4, 96'h4483E880, 1'b0, 4'd4, 8'h83, 4'd5, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'hFFFFFF80, 4'd8},
        // R8 three-operand multiply: index byte, disp8, imm32
        '{1'b1, 4'd8, 96'h6944240810270000, 1'b0, 4'd8, 8'h69, 4'd0, 4'd4, 1'b1, 1'b1, 4'd4, 1'b0, 2'd0, 1'b0, 32'h8, 32'h2710, 4'd8},
        // R1 mode 10 disp32 followed by imm32
        '{1'b1, 4'd10, 96'h81800001_0000FF00_0000, 1'b0, 4'd10, 8'h81, 4'd0, 4'd0, 1'b1, 1'b1, 4'd0, 1'b0, 2'd0, 1'b0, 32'h100, 32'hFF, 4'd1},
        // R5 legacy increment
        '{1'b0, 4'd1, 96'h41, 1'b0, 4'd1, 8'h41, 4'd1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd5},
        // R5 legacy decrement
        '{1'b0, 4'd1, 96'h4F, 1'b0, 4'd1, 8'h4F, 4'd7, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd5},
        // R7 push extended register
        '{1'b1, 4'd2, 96'h4155, 1'b0, 4'd2, 8'h55, 4'd13, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd7},
        // R7 push plain register
        '{1'b1, 4'd1, 96'h53, 1'b0, 4'd1, 8'h53, 4'd3, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd7},
        // R6 bare 0x99
        '{1'b1, 4'd1, 96'h99, 1'b0, 4'd1, 8'h99, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd6},
        // R6 bare with prefix
        '{1'b1, 4'd2, 96'h4899, 1'b0, 4'd2, 8'h99, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd6},
        // R6 bare 0x90
        '{1'b1, 4'd1, 96'h90, 1'b0, 4'd1, 8'h90, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd6},
        // R9 address computation with register form
        '{1'b1, 4'd2, 96'h8DC0, 1'b1, 4'd2, 8'h8D, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd9},
        // R10 unsupported opcode
        '{1'b1, 4'd1, 96'h0F, 1'b1, 4'd1, 8'h0F, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd10},
        // R4 double prefix
        '{1'b1, 4'd2, 96'h4041, 1'b1, 4'd2, 8'h41, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd4},
        // R10 resync: good instruction right after errors (legacy decrement)
        '{1'b0, 4'd1, 96'h4C, 1'b0, 4'd1, 8'h4C, 4'd4, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 32'h0, 32'h0, 4'd10},
        // R8 disp8 then imm8
        '{1'b1, 4'd4, 96'h834510F0, 1'b0, 4'd4, 8'h83, 4'd0, 4'd5, 1'b1, 1'b1, 4'd0, 1'b0, 2'd0, 1'b0, 32'h10, 32'hFFFFFFF0, 4'd8}
    };

    function automatic logic [94:0] actual_rec();
        return {out_error, out_len, out_opcode, out_reg, out_rm, out_mem, out_base_vld,
                out_index, out_index_vld, out_scale, out_ip_rel, out_disp, out_imm};
    endfunction

    function automatic logic [94:0] expect_rec(input vec_t v);
        return {v.err, v.len, v.opc, v.rg, v.rm, v.mem, v.bv, v.idx, v.iv, v.sc, v.ipr, v.disp, v.imm};
    endfunction

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [94:0] act, input logic [94:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic run_vec(input vec_t v);
        bit early = 1'b0;
        long_mode = v.lm;
        for (int i = 0; i < int'(v.n); i++) begin
            @(negedge clk);
            if (out_valid) early = 1'b1;
            in_valid = 1'b1;
            in_byte  = v.b[8*(int'(v.n)-1-i) +: 8];
        end
        @(negedge clk);
        in_valid = 1'b0;
        // R11 record one cycle after last byte, ready low meanwhile
        chk(out_valid && !in_ready && !early, 11, "emit timing",
            95'({early, out_valid, in_ready}), 95'(3'b010));
        chk(actual_rec() == expect_rec(v), int'(v.req), "record", actual_rec(), expect_rec(v));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 state while in reset
        chk(!out_valid && in_ready, 12, "reset state", 95'({out_valid, in_ready}), 95'(2'b01));
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, 12, "after reset", 95'({out_valid, in_ready}), 95'(2'b01));

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R11 idle gaps between bytes change nothing
        long_mode = 1'b1;
        put_byte(8'h89);
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk(!out_valid && in_ready, 11, "gap no output", 95'({out_valid, in_ready}), 95'(2'b01));
        end
        put_byte(8'h45);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        put_byte(8'hF8);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid, 11, "gap emit", 95'(out_valid), 95'(1));
        chk(actual_rec() == expect_rec(VECS[3]), 11, "gap record", actual_rec(), expect_rec(VECS[3]));

        // R12 reset mid-instruction discards partial bytes
        put_byte(8'h81);
        put_byte(8'hC1);
        put_byte(8'h78);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!out_valid && in_ready, 12, "mid reset", 95'({out_valid, in_ready}), 95'(2'b01));
        run_vec(VECS[21]);

        finish_run();
    end
endmodule